// File: doc/BRIEF.md
# Deferred Head Step Controller

This block is the head-positioning control on the drive side of a removable-disk mechanism. The host sends step pulses and a direction level. The block acts on the falling (trailing) edge of each step pulse. It rejects steps that are not allowed and keeps a logical cylinder counter. Each accepted track move becomes a short burst of motor-step strobes with a direction, which go to a separate phase-coil driver.

While the drive is unloaded, the head never moves. A drive is unloaded when there is no medium, the spindle motor is off, or the spindle has not yet run long enough. Steps accepted in that state are only counted. They are kept as a signed net track offset, and the counter alone supplies the track-zero indication. When the drive becomes loaded, the block first finishes the power-on sequence. That sequence is an outward recalibration until the track-zero sensor trips, then a fixed inward move. After that, the block replays the stored offset, one track move at a time.

Top module: `head_step_ctrl`

## Requirements
- R1: A step pulse is taken on the falling edge of `stepIn`, and only while `driveSel` is 1. An accepted step raises `stepAck` for exactly one cycle, on the clock edge that follows the edge where `stepIn` is first seen low.
- R2: A step is rejected (no `stepAck`, no motion, no count) while `writeGate` is 1 and `wrProtect` is 0. With `wrProtect` at 1, `writeGate` does not block steps.
- R3: Two cases reject a step. An outward step (`dirIn` = 0) is rejected while `track00` is 1. An inward step (`dirIn` = 1) is rejected when the logical cylinder equals `MAX_CYL` (81 by default).
- R4: While unloaded (any of `diskPresent`, `motorOn`, `spinSettled` is 0), accepted steps change only the cylinder counter and the stored offset. No `motStep` is issued. `track00` is 1 exactly when the counter is 0. After reset the counter holds `INIT_IN`.
- R5: While loaded, `track00` follows `trk0Sensor`.
- R6: After reset, the first loaded period runs in a fixed order. First come outward track moves until `trk0Sensor` reads 1. Then come `INIT_IN` inward moves. Then the stored net offset is replayed in its own direction, one track per move.
- R7: Each track move produces `MOTOR_PER_TRACK` one-cycle `motStep` strobes, `MSTEP_GAP` cycles apart. `motDirIn` is 1 for inward and 0 for outward. Successive moves start at least `TRACK_GAP` cycles apart.
- R8: During replay, if an outward move is due while `trk0Sensor` is 1, the rest of the outward offset is discarded, no move is made, and the cylinder counter becomes 0.
- R9: If the sensor has not tripped after `RECAL_LIMIT` outward recalibration moves, `recalFail` becomes 1 and stays 1 until reset. The inward power-on move is skipped, and replay follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stepIn | input | 1 | Step pulse, active high, acted on at its falling edge |
| dirIn | input | 1 | Step direction: 1 inward, 0 outward |
| driveSel | input | 1 | Drive selected |
| writeGate | input | 1 | Write gate active |
| wrProtect | input | 1 | Medium write-protected |
| trk0Sensor | input | 1 | Track-zero sensor |
| diskPresent | input | 1 | Medium installed |
| motorOn | input | 1 | Spindle motor commanded on |
| spinSettled | input | 1 | Spindle has run long enough after start |
| motStep | output | 1 | One-cycle motor step request |
| motDirIn | output | 1 | Direction of the motor step: 1 inward |
| track00 | output | 1 | Track-zero status |
| stepAck | output | 1 | One-cycle strobe per accepted step |
| recalFail | output | 1 | Recalibration gave up |

## Verification
The bench builds the block with `TRACK_GAP` = 12, `MSTEP_GAP` = 4, `MOTOR_PER_TRACK` = 2, `RECAL_LIMIT` = 85, `INIT_IN` = 2 and `MAX_CYL` = 81. These short gaps let an 80-track replay and a full 85-move failed recalibration each finish in about a thousand cycles. That puts the step-in ceiling, the recalibration limit and the early stop on the sensor within a short run. A bench-side head model turns motor strobes into a position and drives the track-zero sensor from that position. The ordering of recalibration, inward move and replay is then checked against an independent expectation, strobe by strobe.

// File: rtl/head_step_pkg.sv
package head_step_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic consume;      // take one track off the stored offset, toward zero
    logic dropOutward;  // discard the outward remainder, counter to zero
  } dpCmd_t;

  typedef enum logic [1:0] {PH_RECAL, PH_INWARD, PH_REPLAY} phase_t;
  typedef enum logic       {ST_IDLE, ST_MOVE} moveSt_t;

endpackage

// File: rtl/head_step_dp.sv
module head_step_dp
  import head_step_pkg::*;
#(
  parameter int MAX_CYL  = 81,
  parameter int INIT_CYL = 2,
  parameter int OFF_W    = 9
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stepIn,
  input  logic   dirIn,
  input  logic   driveSel,
  input  logic   writeGate,
  input  logic   wrProtect,
  input  logic   trk0Sensor,
  input  logic   loaded,
  input  dpCmd_t cmd,
  output logic   offsetNz,
  output logic   offsetNeg,
  output logic   track00,
  output logic   stepAck
);

  localparam int CYL_W = $clog2(MAX_CYL + 1);
  localparam logic [CYL_W-1:0] CYL_TOP  = CYL_W'(MAX_CYL);
  localparam logic [CYL_W-1:0] CYL_INIT = CYL_W'(INIT_CYL);
  localparam logic signed [OFF_W-1:0] PLUS1  = OFF_W'(1);
  localparam logic signed [OFF_W-1:0] MINUS1 = -PLUS1;
  localparam logic signed [OFF_W-1:0] ZERO   = '0;

  logic stepD;
  logic [CYL_W-1:0] cyl;
  logic signed [OFF_W-1:0] offset;
  logic signed [OFF_W-1:0] stepDelta, consumeDelta;
  logic fall, wgBlock, outBlock, inBlock, take;

  assign offsetNz  = (offset != ZERO);
  assign offsetNeg = offset[OFF_W-1];
  assign track00   = loaded ? trk0Sensor : (cyl == '0);

  assign fall     = stepD & ~stepIn;
  assign wgBlock  = writeGate & ~wrProtect;
  assign outBlock = ~dirIn & track00;
  assign inBlock  = dirIn & (cyl == CYL_TOP);
  assign take     = fall & driveSel & ~wgBlock & ~outBlock & ~inBlock;

  always_comb begin
    stepDelta    = take ? (dirIn ? PLUS1 : MINUS1) : ZERO;
    consumeDelta = cmd.consume ? (offsetNeg ? PLUS1 : MINUS1) : ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepD   <= 1'b0;
      stepAck <= 1'b0;
      cyl     <= CYL_INIT;
      offset  <= ZERO;
    end else begin
      stepD   <= stepIn;
      stepAck <= take;
      if (cmd.dropOutward) begin
        offset <= stepDelta;
        cyl    <= (take && dirIn) ? CYL_W'(1) : '0;
      end else begin
        offset <= offset + stepDelta + consumeDelta;
        if (take) begin
          if (dirIn)           cyl <= cyl + CYL_W'(1);
          else if (cyl != '0)  cyl <= cyl - CYL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/head_step_fsm.sv
module head_step_fsm
  import head_step_pkg::*;
#(
  parameter int TRACK_GAP       = 12,
  parameter int MSTEP_GAP       = 4,
  parameter int MOTOR_PER_TRACK = 2,
  parameter int RECAL_LIMIT     = 85,
  parameter int INIT_IN         = 2
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   loaded,
  input  logic   trk0Sensor,
  input  logic   offsetNz,
  input  logic   offsetNeg,
  output dpCmd_t cmd,
  output logic   motStep,
  output logic   motDirIn,
  output logic   recalFail
);

  localparam int TW = $clog2(TRACK_GAP + 1);
  localparam int SW = $clog2(MSTEP_GAP + 1);
  localparam int MW = $clog2(MOTOR_PER_TRACK + 1);
  localparam int RW = $clog2(RECAL_LIMIT + 1);
  localparam int IW = $clog2(INIT_IN + 2);
  localparam logic [TW-1:0] T_LAST = TW'(TRACK_GAP - 1);
  localparam logic [SW-1:0] S_LAST = SW'(MSTEP_GAP - 1);
  localparam logic [MW-1:0] M_REST = MW'(MOTOR_PER_TRACK - 1);
  localparam logic [RW-1:0] R_MAX  = RW'(RECAL_LIMIT);
  localparam logic [IW-1:0] I_INIT = IW'(INIT_IN);

  moveSt_t state;
  phase_t  phase;
  logic [TW-1:0] timer;
  logic [SW-1:0] subT;
  logic [MW-1:0] mLeft;
  logic [RW-1:0] tries;
  logic [IW-1:0] inLeft;

  logic startMove, startIn, toInward, toReplay, failNow;

  always_comb begin
    startMove       = 1'b0;
    startIn         = 1'b0;
    toInward        = 1'b0;
    toReplay        = 1'b0;
    failNow         = 1'b0;
    cmd.consume     = 1'b0;
    cmd.dropOutward = 1'b0;
    if (state == ST_IDLE && loaded) begin
      unique case (phase)
        PH_RECAL: begin
          if (trk0Sensor)          toInward  = 1'b1;
          else if (tries == R_MAX) failNow   = 1'b1;
          else                     startMove = 1'b1;
        end
        PH_INWARD: begin
          if (inLeft == '0) toReplay = 1'b1;
          else begin
            startMove = 1'b1;
            startIn   = 1'b1;
          end
        end
        default: begin
          if (offsetNz) begin
            if (offsetNeg && trk0Sensor) cmd.dropOutward = 1'b1;
            else begin
              cmd.consume = 1'b1;
              startMove   = 1'b1;
              startIn     = ~offsetNeg;
            end
          end
        end
      endcase
    end
  end

  // Power-on sequence bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RECAL;
      tries     <= '0;
      inLeft    <= I_INIT;
      recalFail <= 1'b0;
    end else begin
      if (toInward) begin
        phase  <= PH_INWARD;
        inLeft <= I_INIT;
      end
      if (toReplay) phase <= PH_REPLAY;
      if (failNow) begin
        phase     <= PH_REPLAY;
        recalFail <= 1'b1;
      end
      if (startMove && phase == PH_RECAL)  tries  <= tries + RW'(1);
      if (startMove && phase == PH_INWARD) inLeft <= inLeft - IW'(1);
    end
  end

  // Track move: burst of motor strobes inside a fixed window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      timer    <= '0;
      subT     <= '0;
      mLeft    <= '0;
      motStep  <= 1'b0;
      motDirIn <= 1'b0;
    end else begin
      motStep <= 1'b0;
      if (state == ST_IDLE) begin
        if (startMove) begin
          state    <= ST_MOVE;
          timer    <= '0;
          subT     <= '0;
          mLeft    <= M_REST;
          motStep  <= 1'b1;
          motDirIn <= startIn;
        end
      end else begin
        timer <= timer + TW'(1);
        if (mLeft != '0) begin
          if (subT == S_LAST) begin
            motStep <= 1'b1;
            mLeft   <= mLeft - MW'(1);
            subT    <= '0;
          end else begin
            subT <= subT + SW'(1);
          end
        end
        if (timer == T_LAST) state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/head_step_ctrl.sv
module head_step_ctrl
  import head_step_pkg::*;
#(
  parameter int MAX_CYL         = 81,
  parameter int TRACK_GAP       = 12,
  parameter int MSTEP_GAP       = 4,
  parameter int MOTOR_PER_TRACK = 2,
  parameter int RECAL_LIMIT     = 85,
  parameter int INIT_IN         = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic stepIn,
  input  logic dirIn,
  input  logic driveSel,
  input  logic writeGate,
  input  logic wrProtect,
  input  logic trk0Sensor,
  input  logic diskPresent,
  input  logic motorOn,
  input  logic spinSettled,
  output logic motStep,
  output logic motDirIn,
  output logic track00,
  output logic stepAck,
  output logic recalFail
);

  localparam int OFF_W = $clog2(MAX_CYL + 1) + 2;

  logic   loaded, offsetNz, offsetNeg;
  dpCmd_t cmd;

  assign loaded = diskPresent & motorOn & spinSettled;

  head_step_dp #(.MAX_CYL(MAX_CYL), .INIT_CYL(INIT_IN), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stepIn(stepIn), .dirIn(dirIn),
    .driveSel(driveSel), .writeGate(writeGate), .wrProtect(wrProtect),
    .trk0Sensor(trk0Sensor), .loaded(loaded), .cmd(cmd),
    .offsetNz(offsetNz), .offsetNeg(offsetNeg),
    .track00(track00), .stepAck(stepAck)
  );

  head_step_fsm #(.TRACK_GAP(TRACK_GAP), .MSTEP_GAP(MSTEP_GAP),
                  .MOTOR_PER_TRACK(MOTOR_PER_TRACK),
                  .RECAL_LIMIT(RECAL_LIMIT), .INIT_IN(INIT_IN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .loaded(loaded), .trk0Sensor(trk0Sensor),
    .offsetNz(offsetNz), .offsetNeg(offsetNeg), .cmd(cmd),
    .motStep(motStep), .motDirIn(motDirIn), .recalFail(recalFail)
  );

endmodule

// File: rtl/head_step_chk.sv
module head_step_chk (
  input logic clk,
  input logic rst_n,
  input logic stepIn,
  input logic dirIn,
  input logic driveSel,
  input logic writeGate,
  input logic wrProtect,
  input logic motStep,
  input logic track00,
  input logic stepAck,
  input logic recalFail
);

  AST_ACK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    stepAck |-> $past(driveSel)); // R1

  AST_ACK_NOT_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    stepAck |-> !($past(writeGate) && !$past(wrProtect))); // R2

  AST_NO_OUT_PAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stepIn) && !dirIn && track00) |=> !stepAck); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    motStep |=> !motStep); // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    recalFail |=> recalFail); // R9

endmodule

bind head_step_ctrl head_step_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stepIn(stepIn), .dirIn(dirIn),
  .driveSel(driveSel), .writeGate(writeGate), .wrProtect(wrProtect),
  .motStep(motStep), .track00(track00), .stepAck(stepAck),
  .recalFail(recalFail)
);

// File: tb/head_step_ctrl_bench.sv
module head_step_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stepIn = 1'b0, dirIn = 1'b0, driveSel = 1'b1;
  logic writeGate = 1'b0, wrProtect = 1'b0;
  logic diskPresent = 1'b1, motorOn = 1'b0, spinSettled = 1'b1;
  logic forceHi = 1'b0, forceLo = 1'b0;
  logic trk0Sensor;
  logic motStep, motDirIn, track00, stepAck, recalFail;

  int physHalf = 12;   // head position in motor steps
  int nCmp = 0, nBad = 0;
  logic expQ[$];       // expected direction of each motor strobe
  bit done = 0;

  always #2 clk = ~clk;

  assign trk0Sensor = forceHi | (~forceLo & (physHalf <= 1));

  head_step_ctrl #(.MAX_CYL(81), .TRACK_GAP(12), .MSTEP_GAP(4),
                   .MOTOR_PER_TRACK(2), .RECAL_LIMIT(85), .INIT_IN(2)) u_head_step_ctrl (
    .clk(clk), .rst_n(rst_n), .stepIn(stepIn), .dirIn(dirIn),
    .driveSel(driveSel), .writeGate(writeGate), .wrProtect(wrProtect),
    .trk0Sensor(trk0Sensor), .diskPresent(diskPresent), .motorOn(motorOn),
    .spinSettled(spinSettled), .motStep(motStep), .motDirIn(motDirIn),
    .track00(track00), .stepAck(stepAck), .recalFail(recalFail)
  );

  task automatic check(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushMoves(logic dirInward, int tracks);
    for (int i = 0; i < tracks * 2; i++) expQ.push_back(dirInward);
  endtask

  task automatic pulse(logic dir, logic expAck, string req);
    @(negedge clk);
    dirIn  = dir;
    stepIn = 1'b1;
    repeat (2) @(negedge clk);
    stepIn = 1'b0;
    @(negedge clk);
    check(req, stepAck, expAck);
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // Scoreboard monitor: pops one expected direction per motor strobe
  always @(negedge clk) begin
    if (rst_n && motStep) begin
      physHalf = motDirIn ? physHalf + 1 : (physHalf > 0 ? physHalf - 1 : 0);
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R4/R6/R8: actual unexpected strobe dir %0d expected none", motDirIn);
      end else begin
        logic e;
        e = expQ.pop_front();
        if (e != motDirIn) begin
          nBad++;
          $display("FAIL R6/R7: actual dir %0d expected %0d", motDirIn, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: unloaded, counter at 2
    check("R4 reset track00", track00, 0);
    check("R7 reset motStep", motStep, 0);
    check("R1 reset stepAck", stepAck, 0);
    check("R9 reset recalFail", recalFail, 0);

    // Unloaded: steps counted only (R4)
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1, "R4 unloaded in");
    check("R4 counter 5 not zero", track00, 0);
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1, "R4 unloaded out");
    check("R4 counter zero gives track00", track00, 1);
    pulse(1'b0, 1'b0, "R3 out at track zero rejected");
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b1, "R4 unloaded in again");
    check("R4 counter 4 track00", track00, 0);
    driveSel = 1'b0;
    pulse(1'b1, 1'b0, "R1 unselected rejected");
    driveSel = 1'b1;
    writeGate = 1'b1;
    pulse(1'b1, 1'b0, "R2 write gate writable rejected");
    wrProtect = 1'b1;
    pulse(1'b1, 1'b1, "R2 write gate protected accepted");
    writeGate = 1'b0; wrProtect = 1'b0;
    repeat (30) @(negedge clk);
    check("R4 no motion while unloaded", expQ.size(), 0);

    // Load: recal (6 out), 2 in, replay +3 in (R6)
    pushMoves(1'b0, 6);
    pushMoves(1'b1, 2);
    pushMoves(1'b1, 3);
    motorOn = 1'b1;
    repeat (300) @(negedge clk);
    check("R6 sequence drained", expQ.size(), 0);
    check("R6 head at track 5", physHalf, 10);
    check("R5 loaded track00 follows sensor", track00, trk0Sensor);

    // Loaded step goes straight to motion (R7)
    pushMoves(1'b0, 1);
    pulse(1'b0, 1'b1, "R7 loaded out accepted");
    repeat (40) @(negedge clk);
    check("R7 one track out", physHalf, 8);

    // Early stop on sensor (R8)
    motorOn = 1'b0;
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, "R8 queue out");
    forceHi = 1'b1;
    motorOn = 1'b1;
    repeat (40) @(negedge clk);
    check("R8 no outward motion", physHalf, 8);
    check("R5 sensor high shown", track00, 1);
    pulse(1'b0, 1'b0, "R3 loaded out at sensor rejected");
    forceHi = 1'b0;
    @(negedge clk);
    check("R5 sensor low shown", track00, 0);
    pushMoves(1'b1, 1);
    pulse(1'b1, 1'b1, "R8 counter reset then in");
    repeat (40) @(negedge clk);
    check("R8 moved one in", physHalf, 10);

    // Step-in ceiling at 81 (R3): counter is 1, so 80 accepted
    motorOn = 1'b0;
    for (int i = 0; i < 80; i++) pulse(1'b1, 1'b1, "R3 in below ceiling");
    pulse(1'b1, 1'b0, "R3 in at 81 rejected");
    check("R4 counter 81 track00", track00, 0);
    pushMoves(1'b1, 80);
    motorOn = 1'b1;
    repeat (1200) @(negedge clk);
    check("R7 80-track replay drained", expQ.size(), 0);
    check("R7 head position", physHalf, 170);

    // Recalibration failure (R9)
    rst_n = 1'b0;
    forceLo = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pushMoves(1'b0, 85);
    repeat (1300) @(negedge clk);
    check("R9 recal moves drained", expQ.size(), 0);
    check("R9 recalFail set", recalFail, 1);
    repeat (40) @(negedge clk);
    check("R9 no inward after fail", expQ.size(), 0);
    check("R9 recalFail held", recalFail, 1);

    done = 1;
    finishRun();
  end

endmodule